// File: doc/BRIEF.md
# Clocked Serial Transmit Controller

This block is the sending side of a synchronous serial port. Software writes a word into a one-entry holding buffer. The controller moves that word into a shift register and sends it out one bit at a time, least significant bit first. Along with the data it sends a transfer clock that it generates from the system clock with a programmable divider. While a word is being sent, a busy flag is high. If the next word is already waiting when the current one ends, that word follows with no idle clock, so a train of words is sent as one continuous stream.

The controller produces three kinds of requests. A one-cycle DMA request pulse fires each time the buffer hands a word to the shifter, and also when sending is switched on. A single interrupt output carries one of two events, chosen by a select input: the buffer has emptied, or the train has finished. The interrupt output is gated by an interrupt-enable input. A write that arrives while the buffer is still full is dropped and sets a sticky error flag.

Top module: `csx_tx`

## Requirements
- R1: Words of DATA_W bits (8 by default) are sent least significant bit first on `sdata_o`. Data changes together with the falling edge of `sclk_o`, and the receiver should sample it on the rising edge. Whenever `busy_o` is 0, both `sclk_o` and `sdata_o` are held at 1.
- R2: With `div_val` = D, each low half and each high half of `sclk_o` lasts exactly D+1 system clock cycles.
- R3: `busy_o` goes to 1 when a word is loaded into the shifter. When no further word is waiting, it returns to 0 at the end of the high half of the last bit.
- R4: If the buffer holds a word when the last bit of the current word ends, that word is loaded at once. `sclk_o` falls straight into the new word's first bit, with a high half of exactly D+1 cycles, and `busy_o` stays 1 for the whole train.
- R5: `dma_req_o` pulses high for one cycle after every transfer from the buffer to the shifter, and after every 0-to-1 change of `tx_en`.
- R6: With `int_sel` = 0 (buffer-empty source), an interrupt event occurs on every transfer from the buffer to the shifter and on every 0-to-1 change of `tx_en`.
- R7: With `int_sel` = 1 (finished source), an interrupt event occurs once at the end of the last bit of a train, not between the words of a train. One also occurs when `tx_en` changes from 1 to 0.
- R8: An interrupt event appears on `irq_o` as a one-cycle pulse only when `int_en` is 1. When `int_en` is 0, `irq_o` stays 0.
- R9: A write with `wr_en` while the buffer is full is ignored: the buffered word is kept, and `ovr_err_o` is set and stays set while `tx_en` is 1. A write while `tx_en` is 0 is also ignored. `ovr_err_o` is cleared while `tx_en` is 0.
- R10: Setting `tx_en` to 0 stops a word in progress, empties the buffer, drops `busy_o` to 0 and returns `sclk_o` to 1. Nothing is sent after `tx_en` is set again until a new word is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| int_en | input | 1 | Interrupt output enable |
| int_sel | input | 1 | Interrupt source: 0 buffer-empty, 1 finished |
| div_val | input | DIV_W | Divider value D; each half bit lasts D+1 cycles |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | DATA_W | Word to send |
| sclk_o | output | 1 | Transfer clock, idles high |
| sdata_o | output | 1 | Serial data, LSB first |
| busy_o | output | 1 | Transmit status |
| irq_o | output | 1 | Interrupt request pulse |
| dma_req_o | output | 1 | DMA transfer request pulse |
| ovr_err_o | output | 1 | Sticky write-while-full error |

## Verification
The bench builds the block with the default DATA_W of 8 and DIV_W of 8. It changes `div_val` at run time, first to 2 and then to 0. A divider of 2 gives three-cycle half bits, long enough to place a second write inside a word and a third write while the buffer is full. A divider of 0 reaches the shortest one-cycle half bit. Here a word boundary inside a train can only be seen as a missing idle cycle. Both interrupt sources, a gated interrupt output and an abort in the middle of a word are each exercised at one of these settings.

// File: rtl/csx_pkg.sv
package csx_pkg;
  typedef struct packed {
    logic empty_ev;
    logic done_ev;
    logic dma_ev;
  } csx_ev_t;
endpackage

// File: rtl/csx_clkdiv.sv
module csx_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(div)) |-> (cnt_q <= div));
endmodule

// File: rtl/csx_txbuf.sv
module csx_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic              full_q, full_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    full_d  = full_q;
    err_d   = err_q;
    data_d  = wdata;
    data_en = 1'b0;
    if (!enable) begin
      full_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (wr && !full_q) begin
        data_en = 1'b1;
        full_d  = 1'b1;
      end else if (wr && full_q) begin
        err_d = 1'b1;
      end
      if (take) full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      err_q  <= err_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign err_o  = err_q;

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && enable) |=> err_q);
  // R9
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && wr && enable) |=> $stable(data_q));
endmodule

// File: rtl/csx_shift.sv
module csx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              tick,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy_o,
  output logic              word_end_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CW-1:0]     bcnt_q, bcnt_d;
  logic              sclk_q, sclk_d;
  logic              busy_q, busy_d;

  assign word_end_o = busy_q && sclk_q && tick && (bcnt_q == LAST);

  always_comb begin
    sr_d   = sr_q;
    bcnt_d = bcnt_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    if (abort) begin
      busy_d = 1'b0;
      sclk_d = 1'b1;
    end else if (load) begin
      sr_d   = ld_data;
      bcnt_d = '0;
      sclk_d = 1'b0;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
      end else if (bcnt_q != LAST) begin
        sclk_d = 1'b0;
        sr_d   = sr_q >> 1;
        bcnt_d = bcnt_q + 1'b1;
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      sclk_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      bcnt_q <= bcnt_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign busy_o  = busy_q;
  assign sdata_o = busy_q ? sr_q[0] : 1'b1;

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sclk_q && sdata_o));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (!sclk_q && bcnt_q == '0));
endmodule

// File: rtl/csx_tx.sv
module csx_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              int_en,
  input  logic              int_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              ovr_err_o
);
  import csx_pkg::*;

  logic              buf_full, word_end, tick, load, busy;
  logic [DATA_W-1:0] buf_data;
  logic              en_q, en_rise, en_fall;
  logic              irq_q, dma_q;
  csx_ev_t           ev;

  assign en_rise = tx_en && !en_q;
  assign en_fall = !tx_en && en_q;
  assign load    = tx_en && buf_full && (!busy || word_end);

  csx_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(tx_en), .wr(wr_en), .wdata(wr_data),
    .take(load), .full_o(buf_full), .data_o(buf_data), .err_o(ovr_err_o)
  );

  csx_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load), .div(div_val),
    .tick(tick)
  );

  csx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(!tx_en), .load(load), .ld_data(buf_data),
    .tick(tick), .sclk_o(sclk_o), .sdata_o(sdata_o), .busy_o(busy),
    .word_end_o(word_end)
  );

  always_comb begin
    ev.empty_ev = load || en_rise;
    ev.done_ev  = (word_end && !load) || en_fall;
    ev.dma_ev   = load || en_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      en_q  <= tx_en;
      irq_q <= int_en && (int_sel ? ev.done_ev : ev.empty_ev);
      dma_q <= ev.dma_ev;
    end
  end

  assign busy_o    = busy;
  assign irq_o     = irq_q;
  assign dma_req_o = dma_q;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(int_en) |-> !irq_o);
  // R5
  dma_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> dma_req_o);
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy_o && sclk_o));
endmodule

// File: tb/csx_tx_tb.sv
module csx_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, int_en, int_sel, wr_en;
  logic [7:0] div_val, wr_data;
  logic       sclk_o, sdata_o, busy_o, irq_o, dma_req_o, ovr_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0, dma_cnt = 0, busy_falls = 0;
  int cur_div = 2;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csx_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .int_en(int_en),
    .int_sel(int_sel), .div_val(div_val), .wr_en(wr_en), .wr_data(wr_data),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .busy_o(busy_o), .irq_o(irq_o),
    .dma_req_o(dma_req_o), .ovr_err_o(ovr_err_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: each accepted write pushes the expected word.
  task automatic put_word(input logic [7:0] w, input logic expect_sent);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    if (expect_sent) exp_q.push_back(w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (!busy_o) @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic clear_counts();
    irq_cnt = 0; dma_cnt = 0; busy_falls = 0;
  endtask

  // Monitor: rebuilds words from the serial line and checks half-bit lengths.
  logic       p_sclk = 1'b1, p_busy = 1'b0;
  logic [7:0] rx = '0;
  int         nb = 0, plen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_o) irq_cnt++;
      if (dma_req_o) dma_cnt++;
      if (p_busy && !busy_o) busy_falls++;
      if (sclk_o == p_sclk) plen++;
      else begin
        if (sclk_o) chk(plen == cur_div + 1, "R2 low half length", plen, cur_div + 1);
        else if (p_busy) chk(plen == cur_div + 1, "R4 high half length in train", plen, cur_div + 1);
        plen = 1;
      end
      if (sclk_o && !p_sclk) begin
        rx = {sdata_o, rx[7:1]};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word sent", int'(rx), -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rx == e, "R1 serial word", int'(rx), int'(e));
          end
        end
      end
      if (!busy_o && !(sclk_o && !p_sclk)) nb = 0;
      p_sclk = sclk_o;
      p_busy = busy_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; int_en = 1'b1; int_sel = 1'b0;
    wr_en = 1'b0; wr_data = '0; div_val = 8'd2; cur_div = 2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(sclk_o == 1'b1 && sdata_o == 1'b1, "R1 idle line after reset", {sclk_o, sdata_o}, 3);
    chk(busy_o == 1'b0, "R3 busy after reset", busy_o, 0);
    chk(irq_o == 0 && dma_req_o == 0 && ovr_err_o == 0, "R8 outputs after reset",
        {irq_o, dma_req_o, ovr_err_o}, 0);

    // Enable with buffer-empty source
    clear_counts();
    @(negedge clk); tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(dma_cnt == 1, "R5 dma on enable", dma_cnt, 1);
    chk(irq_cnt == 1, "R6 empty irq on enable", irq_cnt, 1);

    // Single word
    put_word(8'hA5, 1'b1);
    wait_idle();
    @(negedge clk);
    chk(busy_o == 1'b0, "R3 busy clears after single word", busy_o, 0);
    chk(sclk_o == 1'b1 && sdata_o == 1'b1, "R1 idle after word", {sclk_o, sdata_o}, 3);
    chk(dma_cnt == 2, "R5 dma on load", dma_cnt, 2);
    chk(irq_cnt == 2, "R6 empty irq on load", irq_cnt, 2);

    // Back-to-back train plus write while full
    clear_counts();
    put_word(8'h3C, 1'b1);
    repeat (3) @(negedge clk);
    put_word(8'hC3, 1'b1);
    put_word(8'h5A, 1'b0);
    chk(ovr_err_o == 1'b1, "R9 error on write while full", ovr_err_o, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(busy_falls == 1, "R4 busy held through train", busy_falls, 1);
    chk(dma_cnt == 2, "R5 dma per load in train", dma_cnt, 2);
    chk(irq_cnt == 2, "R6 empty irq per load in train", irq_cnt, 2);
    chk(ovr_err_o == 1'b1, "R9 error sticky", ovr_err_o, 1);
    chk(exp_q.size() == 0, "R9 dropped word not sent", exp_q.size(), 0);

    // Finished source
    int_sel = 1'b1;
    clear_counts();
    put_word(8'h81, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq_cnt == 1, "R7 finished irq single word", irq_cnt, 1);
    clear_counts();
    put_word(8'h11, 1'b1);
    repeat (3) @(negedge clk);
    put_word(8'h22, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq_cnt == 1, "R7 one finished irq per train", irq_cnt, 1);

    // Interrupt gated off
    int_en = 1'b0;
    clear_counts();
    put_word(8'h7E, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq_cnt == 0, "R8 no irq when disabled", irq_cnt, 0);
    chk(dma_cnt == 1, "R5 dma independent of irq enable", dma_cnt, 1);

    // Abort mid-word
    int_en = 1'b1;
    clear_counts();
    put_word(8'hF0, 1'b0);
    repeat (10) @(negedge clk);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0 && sclk_o == 1'b1, "R10 abort idles line", {busy_o, sclk_o}, 1);
    chk(irq_cnt == 1, "R7 finished irq on disable", irq_cnt, 1);
    chk(ovr_err_o == 1'b0, "R9 error cleared while disabled", ovr_err_o, 0);
    put_word(8'h99, 1'b0);
    @(negedge clk); tx_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(busy_falls == 1 && busy_o == 1'b0, "R10 nothing sent after re-enable",
        busy_falls, 1);

    // Shortest divider, two-word train
    div_val = 8'd0; cur_div = 0;
    clear_counts();
    put_word(8'h6B, 1'b1);
    put_word(8'hD4, 1'b1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(busy_falls == 1, "R4 no gap at divider 0", busy_falls, 1);
    chk(irq_cnt == 1, "R7 finished irq at divider 0", irq_cnt, 1);
    chk(exp_q.size() == 0, "R1 all words received", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule